// File: doc/BRIEF.md
# Flash Identification and Interrupt Register File

This block sits at the front of a flash controller. It presents a small memory-mapped register space over a 16-bit bus. Software reads the part's identification from it. It also reads the data-buffer size, programs a configuration word and manages an interrupt status word. The manufacturer, device and version identifiers arrive as static inputs. Geometry values are decoded from fields of the device identifier and driven out as plain status pins for the rest of the controller.

A single interrupt line is derived from the interrupt status word and a polarity bit in the configuration word. Writing the read-identification code to the command register copies the low bytes of the manufacturer ID, the device ID and the write-protect status into the first three words of a small boot-buffer area. It also flags completion in the interrupt status word.

The bus request side has no back-pressure. A request is taken in every cycle that `req_valid` is high, so there is no ready signal. A read answers exactly one cycle later with `rsp_valid` high for one cycle. A write never produces a response.

Top module: `flash_id_regs`

## Requirements
- R1: Reads of 0xF000, 0xF001 and 0xF002 return `man_id`, `dev_id` and `ver_id` respectively, each as a full 16-bit value.
- R2: A read of 0xF003 returns the data buffer size 2^PAGE_SHIFT (2048 with the default PAGE_SHIFT of 11).
- R3: `dev_bytes` equals 2^(24 + dev_id[6:4]). `blk_count` equals `dev_bytes` divided by 2^(PAGE_SHIFT+6), because there are 64 pages per block. `density_mask` equals 2^(6 + dev_id[6:4]) when dev_id[3] is 1 and 0 otherwise.
- R4: `irq` equals int_status[15] XOR NOT cfg0[6]. After reset cfg0 is 0x0040 and int_status is 0x0000, so `irq` starts low. `irq` follows a write to 0xF221 (cfg0) or 0xF241 (int_status) from the clock edge that stores the write.
- R5: Writing 0x0090 to the command register 0xF220 sets boot words 0, 1 and 2 to {8'h00, man_id[7:0]}, {8'h00, dev_id[7:0]} and {8'h00, wp_status[7:0]}. Boot word 3 is left unchanged.
- R6: The read-identification command sets int_status bit 15 at the same edge that loads the boot words.
- R7: Writes to 0xF000–0xF003 and 0xF24E (write-protect status, read-only) have no effect. Reads of undecoded addresses return 0.
- R8: Writing any command code other than 0x0090 leaves the boot words unchanged. The code written can be read back from 0xF220.
- R9: A read request produces `rsp_valid` high with its data exactly one cycle later. A write request produces no response.
- R10: Boot words at addresses 0x0000–0x0003 are readable and writable over the bus, and reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Register word address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after read request) |
| rsp_rdata | output | 16 | Read data |
| man_id | input | 16 | Static manufacturer identifier |
| dev_id | input | 16 | Static device identifier |
| ver_id | input | 16 | Static version identifier |
| wp_status | input | 16 | Write-protect status |
| irq | output | 1 | Interrupt line with programmable polarity |
| dev_bytes | output | 32 | Device capacity in bytes |
| blk_count | output | 32 | Number of erase blocks |
| density_mask | output | 16 | Density mask, 0 when unused |

## Verification
The geometry decode is tried with device identifiers whose size field differs and whose density bit is set in one case and clear in the other. This separates a wrong bit slice from a wrong mask gate. The interrupt line is walked through all four combinations of status bit 15 and polarity bit 6, which exposes a missing inversion or a swapped operand. The identification command is issued after the boot words have been filled with other values. That shows which words it overwrites and which it must keep, and a second, unrelated command shows that it does not trigger the load. Writes aimed at read-only addresses, followed by read-backs, separate a decoder that ignores them from one that stores them somewhere.

// File: rtl/flash_id_pkg.sv
package flash_id_pkg;
  localparam logic [15:0] ADR_MAN   = 16'hF000;
  localparam logic [15:0] ADR_DEV   = 16'hF001;
  localparam logic [15:0] ADR_VER   = 16'hF002;
  localparam logic [15:0] ADR_BUFSZ = 16'hF003;
  localparam logic [15:0] ADR_CMD   = 16'hF220;
  localparam logic [15:0] ADR_CFG0  = 16'hF221;
  localparam logic [15:0] ADR_INT   = 16'hF241;
  localparam logic [15:0] ADR_WP    = 16'hF24E;
  localparam logic [15:0] CMD_READ_ID = 16'h0090;
  localparam logic [15:0] CFG0_RESET  = 16'h0040;

  typedef struct packed {
    logic        valid;
    logic        write;
    logic [15:0] addr;
    logic [15:0] wdata;
  } bus_req_t;
endpackage

// File: rtl/flash_id_geom.sv
module flash_id_geom #(
  parameter int PAGE_SHIFT     = 11,
  parameter int PAGES_LOG2     = 6,
  parameter int SIZE_BASE_LOG2 = 24,
  parameter int MASK_BASE_LOG2 = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] dev_id,
  output logic [31:0] dev_bytes,
  output logic [31:0] blk_count,
  output logic [15:0] density_mask,
  output logic [15:0] buf_size
);
  localparam int BLK_SHIFT = PAGE_SHIFT + PAGES_LOG2;

  logic [2:0] dens;
  logic [4:0] size_sh;
  logic [4:0] mask_sh;

  assign dens    = dev_id[6:4];
  assign size_sh = 5'(SIZE_BASE_LOG2) + {2'b00, dens};
  assign mask_sh = 5'(MASK_BASE_LOG2) + {2'b00, dens};

  always_comb begin
    dev_bytes    = 32'd1 << size_sh;
    blk_count    = dev_bytes >> BLK_SHIFT;
    density_mask = dev_id[3] ? (16'd1 << mask_sh) : 16'd0;
    buf_size     = 16'd1 << PAGE_SHIFT;
  end

  AST_MASK_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(density_mask)) else $error("density mask not power of two"); // R3
  AST_BYTES_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dev_bytes) == 1) else $error("capacity not power of two"); // R3
endmodule

// File: rtl/flash_id_irq.sv
module flash_id_irq #(
  parameter int          DATA_W   = 16,
  parameter int          INT_BIT  = 15,
  parameter int          POL_BIT  = 6,
  parameter logic [15:0] CFG_INIT = 16'h0040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              int_we,
  input  logic              id_done,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cfg0_q,
  output logic [DATA_W-1:0] int_q,
  output logic              irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg0_q <= DATA_W'(CFG_INIT);
    end else if (cfg_we) begin
      cfg0_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q <= '0;
    end else if (int_we) begin
      int_q <= wdata;
    end else if (id_done) begin
      int_q[INT_BIT] <= 1'b1;
    end
  end

  assign irq = int_q[INT_BIT] ^ ~cfg0_q[POL_BIT];

  AST_IDCMD_SETS_INT: assert property (@(posedge clk) disable iff (!rst_n)
    (id_done && !int_we) |=> int_q[INT_BIT]) else $error("id cmd did not flag"); // R6
  AST_INT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_we && !id_done) |=> $stable(int_q)) else $error("int status moved"); // R4
endmodule

// File: rtl/flash_id_bootbuf.sv
module flash_id_bootbuf #(
  parameter int DATA_W     = 16,
  parameter int BOOT_WORDS = 4,
  parameter int ID_WORDS   = 3,
  parameter int IDX_W      = $clog2(BOOT_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              load_id,
  input  logic [7:0]        man_lo,
  input  logic [7:0]        dev_lo,
  input  logic [7:0]        wp_lo,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] words [BOOT_WORDS];
  logic [7:0]        id_bytes [ID_WORDS];

  assign id_bytes[0] = man_lo;
  assign id_bytes[1] = dev_lo;
  assign id_bytes[2] = wp_lo;

  for (genvar i = 0; i < BOOT_WORDS; i++) begin : g_word
    if (i < ID_WORDS) begin : g_idw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          words[i] <= '0;
        end else if (load_id) begin
          words[i] <= DATA_W'(id_bytes[i]);
        end else if (wr_en && wr_idx == IDX_W'(i)) begin
          words[i] <= wdata;
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          words[i] <= '0;
        end else if (wr_en && wr_idx == IDX_W'(i)) begin
          words[i] <= wdata;
        end
      end
    end
  end

  assign rd_data = words[rd_idx];

  AST_ID_WORD0: assert property (@(posedge clk) disable iff (!rst_n)
    load_id |=> words[0] == DATA_W'($past(man_lo))) else $error("word0 load"); // R5
  AST_ID_WORD2: assert property (@(posedge clk) disable iff (!rst_n)
    load_id |=> words[2] == DATA_W'($past(wp_lo))) else $error("word2 load"); // R5
endmodule

// File: rtl/flash_id_regs.sv
module flash_id_regs
  import flash_id_pkg::*;
#(
  parameter int PAGE_SHIFT = 11,
  parameter int BOOT_WORDS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic [15:0] req_wdata,
  output logic        rsp_valid,
  output logic [15:0] rsp_rdata,
  input  logic [15:0] man_id,
  input  logic [15:0] dev_id,
  input  logic [15:0] ver_id,
  input  logic [15:0] wp_status,
  output logic        irq,
  output logic [31:0] dev_bytes,
  output logic [31:0] blk_count,
  output logic [15:0] density_mask
);
  localparam int IDX_W = (BOOT_WORDS > 1) ? $clog2(BOOT_WORDS) : 1;

  bus_req_t    req;
  logic        wr, rd, boot_hit;
  logic [15:0] buf_size, cfg0_q, int_q, cmd_q, boot_rd, rd_mux;
  logic        id_load;

  assign req.valid = req_valid;
  assign req.write = req_write;
  assign req.addr  = req_addr;
  assign req.wdata = req_wdata;

  assign wr       = req.valid && req.write;
  assign rd       = req.valid && !req.write;
  assign boot_hit = req.addr < 16'(BOOT_WORDS);
  assign id_load  = wr && req.addr == ADR_CMD && req.wdata == CMD_READ_ID;

  flash_id_geom #(.PAGE_SHIFT(PAGE_SHIFT)) u_geom (
    .clk(clk), .rst_n(rst_n), .dev_id(dev_id),
    .dev_bytes(dev_bytes), .blk_count(blk_count),
    .density_mask(density_mask), .buf_size(buf_size)
  );

  flash_id_irq #(.CFG_INIT(CFG0_RESET)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(wr && req.addr == ADR_CFG0),
    .int_we(wr && req.addr == ADR_INT),
    .id_done(id_load), .wdata(req.wdata),
    .cfg0_q(cfg0_q), .int_q(int_q), .irq(irq)
  );

  flash_id_bootbuf #(.BOOT_WORDS(BOOT_WORDS), .IDX_W(IDX_W)) u_boot (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr && boot_hit), .wr_idx(req.addr[IDX_W-1:0]),
    .wdata(req.wdata), .load_id(id_load),
    .man_lo(man_id[7:0]), .dev_lo(dev_id[7:0]), .wp_lo(wp_status[7:0]),
    .rd_idx(req.addr[IDX_W-1:0]), .rd_data(boot_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else if (wr && req.addr == ADR_CMD) cmd_q <= req.wdata;
  end

  always_comb begin
    if (boot_hit) begin
      rd_mux = boot_rd;
    end else begin
      unique case (req.addr)
        ADR_MAN:   rd_mux = man_id;
        ADR_DEV:   rd_mux = dev_id;
        ADR_VER:   rd_mux = ver_id;
        ADR_BUFSZ: rd_mux = buf_size;
        ADR_CMD:   rd_mux = cmd_q;
        ADR_CFG0:  rd_mux = cfg0_q;
        ADR_INT:   rd_mux = int_q;
        ADR_WP:    rd_mux = wp_status;
        default:   rd_mux = 16'h0000;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      rsp_rdata <= rd ? rd_mux : 16'h0000;
    end
  end

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid) else $error("missing response"); // R9
  AST_NO_RSP_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rsp_valid) else $error("spurious response"); // R9
  AST_UNDECODED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !boot_hit && req.addr[15:12] != 4'hF) |=> rsp_rdata == 16'h0000)
    else $error("undecoded read nonzero"); // R7
endmodule

// File: tb/tb_flash_id_regs.sv
module tb_flash_id_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [15:0] man_id = 16'h00EC, dev_id = 16'h0058, ver_id = 16'h0031, wp_status = 16'h0204;
  logic        irq;
  logic [31:0] dev_bytes, blk_count;
  logic [15:0] density_mask;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #4 clk = ~clk;

  flash_id_regs dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: pops expected reads as responses appear (R9)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rsp_valid) begin
        if (exp_q.size() == 0) chk("R9 unexpected response", 32'(rsp_rdata), 32'hFFFF_FFFF);
        else chk(tag_q.pop_front(), 32'(rsp_rdata), 32'(exp_q.pop_front()));
      end else if (exp_q.size() != 0 && !req_valid) begin
        chk("R9 response missing", 32'(exp_q.size()), 32'd0);
        void'(exp_q.pop_front()); void'(tag_q.pop_front());
      end
    end
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4 reset irq", 32'(irq), 32'd0);
    bus_rd(16'hF221, 16'h0040, "R4 reset cfg0");
    bus_rd(16'hF241, 16'h0000, "R4 reset int");
    bus_rd(16'h0001, 16'h0000, "R10 reset boot1");

    bus_rd(16'hF000, 16'h00EC, "R1 man id");
    bus_rd(16'hF001, 16'h0058, "R1 dev id");
    bus_rd(16'hF002, 16'h0031, "R1 ver id");
    bus_rd(16'hF003, 16'd2048, "R2 buffer size");

    // R3 geometry, density bit set, size field 5
    chk("R3 bytes a", dev_bytes, 32'h2000_0000);
    chk("R3 blocks a", blk_count, 32'd4096);
    chk("R3 mask a", 32'(density_mask), 32'd2048);
    dev_id = 16'h0020; #1;
    chk("R3 bytes b", dev_bytes, 32'h0400_0000);
    chk("R3 blocks b", blk_count, 32'd512);
    chk("R3 mask b", 32'(density_mask), 32'd0);
    dev_id = 16'h0078; #1;
    chk("R3 bytes c", dev_bytes, 32'h8000_0000);
    chk("R3 mask c", 32'(density_mask), 32'd8192);
    dev_id = 16'h0058;

    // R4 all four polarity/status combinations
    bus_wr(16'hF241, 16'h8000);
    chk("R4 int1 pol1", 32'(irq), 32'd1);
    bus_wr(16'hF221, 16'h0000);
    chk("R4 int1 pol0", 32'(irq), 32'd0);
    bus_wr(16'hF241, 16'h0000);
    chk("R4 int0 pol0", 32'(irq), 32'd1);
    bus_wr(16'hF221, 16'h0040);
    chk("R4 int0 pol1", 32'(irq), 32'd0);

    // R10 boot words writable
    bus_wr(16'h0000, 16'hFFFF);
    bus_wr(16'h0003, 16'h1234);
    bus_rd(16'h0000, 16'hFFFF, "R10 boot0 write");
    bus_rd(16'h0003, 16'h1234, "R10 boot3 write");

    // R8 other command ignored
    bus_wr(16'hF220, 16'h00F0);
    bus_rd(16'h0000, 16'hFFFF, "R8 boot0 unchanged");
    bus_rd(16'hF220, 16'h00F0, "R8 cmd readback");
    chk("R8 no int flag", 32'(irq), 32'd0);

    // R5 / R6 identification command
    bus_wr(16'hF220, 16'h0090);
    chk("R6 irq after id", 32'(irq), 32'd1);
    bus_rd(16'h0000, 16'h00EC, "R5 boot0 man");
    bus_rd(16'h0001, 16'h0058, "R5 boot1 dev");
    bus_rd(16'h0002, 16'h0004, "R5 boot2 wp");
    bus_rd(16'h0003, 16'h1234, "R5 boot3 kept");
    bus_rd(16'hF241, 16'h8000, "R6 int bit15");

    // R7 read-only writes ignored, undecoded reads zero
    bus_wr(16'hF000, 16'hAAAA);
    bus_wr(16'hF003, 16'h5555);
    bus_wr(16'hF24E, 16'h7777);
    bus_rd(16'hF000, 16'h00EC, "R7 man after write");
    bus_rd(16'hF003, 16'd2048, "R7 bufsz after write");
    bus_rd(16'hF24E, 16'h0204, "R7 wp after write");
    bus_rd(16'h1234, 16'h0000, "R7 undecoded");
    bus_rd(16'hF004, 16'h0000, "R7 undecoded F004");

    // R9 back-to-back reads
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'hF001;
    exp_q.push_back(16'h0058); tag_q.push_back("R9 b2b first");
    @(negedge clk);
    req_addr = 16'hF002;
    exp_q.push_back(16'h0031); tag_q.push_back("R9 b2b second");
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 queue drained", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule